// File: doc/BRIEF.md
# Cache Line Store Merge Unit

This unit holds the data words of one cache line in registers and applies a store hit to it. The word inside the line is picked from the byte address. A byte, a halfword or a full word is then merged into that word. Every bit outside the stored lanes keeps its old value.

Which lanes a narrow store lands in depends on a big-endian mode input. The lane number is the low address bits XOR-ed with a mode-dependent constant. The unit also keeps two sticky dirty flags, one for each half of the line, so that a later clean only needs to write back the half that changed. A clear input drops both flags once a clean has finished. Line fill, eviction and tag lookup are handled elsewhere.

Top module: `line_merge`

## Requirements
- R1: While reset (rst_n low) is held, every line word reads 0 and both dirty flags read 0.
- R2: A store with size code 2 (word) replaces all 32 bits of the word selected by addr[4:2]. The result shows on line_words one clock edge after the store.
- R3: A store with size code 1 (halfword) writes wdata[15:0] at bit offset 8*(((big_endian ? 2 : 0) XOR addr[1:0]) AND 2). The other 16 bits of the word are kept.
- R4: A store with size code 0 (byte) writes wdata[7:0] at bit offset 8*((big_endian ? 3 : 0) XOR addr[1:0]). The other 24 bits of the word are kept.
- R5: A store never changes any word other than the one selected by addr[4:2]. Word k sits at line_words[32k+31:32k].
- R6: An accepted store to word index below WORDS/2 sets dirty_lo. An accepted store to any other index sets dirty_hi.
- R7: Dirty flags are sticky: a store never clears either flag, and the flags persist while no clear is applied.
- R8: dirty_clr clears both flags on the next edge. A store in the same cycle still sets the flag of its own half.
- R9: Size code 3 is reserved: such a store changes no word and sets no dirty flag.
- R10: With wr_en low, the line words do not change.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_en | input | 1 | Store strobe |
| addr | input | IDX_W+2 (5) | Byte address within the line |
| size | input | 2 | 0 byte, 1 halfword, 2 word, 3 reserved |
| wdata | input | 32 | Store data, right-aligned |
| big_endian | input | 1 | Selects big-endian lane numbering |
| dirty_clr | input | 1 | Clears both dirty flags |
| line_words | output | WORDS*32 (256) | All line words, word k at bits 32k+31:32k |
| dirty_lo | output | 1 | First half of the line modified |
| dirty_hi | output | 1 | Second half of the line modified |

## Verification
Every result of this unit is registered, so the merged word and both dirty flags are due exactly one rising edge after the store or clear is presented. The bench drives inputs on the falling edge and lets one rising edge pass. It samples on the following falling edge and compares the whole line with a bench model updated by arithmetic offsets. The sweep covers every word index, size code, endian mode and low address pair. Dirty flag cases are run in short sequences, and each step is read back one edge later in the same way.

// File: rtl/line_merge.sv
module line_merge #(
  parameter int WORDS = 8
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  wr_en,
  input  logic [$clog2(WORDS)+1:0] addr,
  input  logic [1:0]            size,
  input  logic [31:0]           wdata,
  input  logic                  big_endian,
  input  logic                  dirty_clr,
  output logic [WORDS*32-1:0]   line_words,
  output logic                  dirty_lo,
  output logic                  dirty_hi
);
  localparam int IDX_W = $clog2(WORDS);
  localparam int HALF  = WORDS / 2;

  wire [IDX_W-1:0] idx = addr[IDX_W+1:2];

  logic [1:0]  lane;
  logic [31:0] mask, ins;
  logic        legal;

  always_comb begin
    legal = 1'b1;
    lane  = 2'd0;
    mask  = '0;
    ins   = wdata;
    case (size)
      2'd0: begin
        lane = {2{big_endian}} ^ addr[1:0];
        mask = 32'h0000_00FF << {lane, 3'b000};
        ins  = {4{wdata[7:0]}};
      end
      2'd1: begin
        lane = {big_endian ^ addr[1], 1'b0};
        mask = 32'h0000_FFFF << {lane, 3'b000};
        ins  = {2{wdata[15:0]}};
      end
      2'd2: mask = '1;
      default: legal = 1'b0;
    endcase
  end

  wire do_wr  = wr_en && legal;
  wire low_hf = idx < IDX_W'(HALF);

  logic [31:0] word_q [WORDS];

  for (genvar g = 0; g < WORDS; g++) begin : g_word
    always_ff @(posedge clk) begin
      if (!rst_n)
        word_q[g] <= '0;
      else if (do_wr && idx == IDX_W'(g))
        word_q[g] <= (word_q[g] & ~mask) | (ins & mask);
    end
    assign line_words[g*32 +: 32] = word_q[g];
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      dirty_lo <= 1'b0;
      dirty_hi <= 1'b0;
    end else begin
      dirty_lo <= (dirty_lo & ~dirty_clr) | (do_wr &  low_hf);
      dirty_hi <= (dirty_hi & ~dirty_clr) | (do_wr & ~low_hf);
    end
  end

  // R6
  lo_mark_chk: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en && size != 2'd3 && !addr[IDX_W+1] |=> dirty_lo);
  // R6
  hi_mark_chk: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en && size != 2'd3 && addr[IDX_W+1] |=> dirty_hi);
  // R7
  sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
    dirty_lo && dirty_hi && !dirty_clr |=> dirty_lo && dirty_hi);
  // R8
  clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    dirty_clr && !wr_en |=> !dirty_lo && !dirty_hi);
  // R9
  reserved_chk: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en && size == 2'd3 |=> $stable(line_words));
  // R10
  idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_en |=> $stable(line_words));
endmodule

// File: tb/line_merge_bench.sv
module line_merge_bench;
  localparam int WORDS = 8;
  logic clk = 0, rst_n = 0, wr_en = 0, big_endian = 0, dirty_clr = 0;
  logic [4:0] addr = '0;
  logic [1:0] size = '0;
  logic [31:0] wdata = '0;
  logic [WORDS*32-1:0] line_words;
  logic dirty_lo, dirty_hi;
  logic [31:0] model [WORDS];
  int checks = 0, errors = 0;

  line_merge #(.WORDS(WORDS)) u_line_merge (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .addr(addr), .size(size),
    .wdata(wdata), .big_endian(big_endian), .dirty_clr(dirty_clr),
    .line_words(line_words), .dirty_lo(dirty_lo), .dirty_hi(dirty_hi));

  always #10 clk = ~clk;

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic check_line(input string req);
    for (int k = 0; k < WORDS; k++) check(req, line_words[k*32 +: 32], model[k]);
  endtask

  task automatic step(input logic we, input logic [4:0] a, input logic [1:0] sz,
                      input logic [31:0] d, input logic be, input logic clr);
    @(negedge clk);
    wr_en = we; addr = a; size = sz; wdata = d; big_endian = be; dirty_clr = clr;
    @(negedge clk);
    wr_en = 0; dirty_clr = 0;
  endtask

  initial begin
    #2_000_000;
    errors++; checks++;
    $display("FAIL watchdog actual=running expected=done");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    int n;
    int off;
    logic [31:0] d;
    for (int k = 0; k < WORDS; k++) model[k] = '0;
    repeat (3) @(negedge clk);
    // R1
    check_line("R1");
    check("R1", {30'd0, dirty_hi, dirty_lo}, 32'd0);
    @(negedge clk); rst_n = 1;

    n = 1;
    // R2 R3 R4 R5 R9: sweep index, size, mode, low address bits
    for (int be = 0; be < 2; be++)
      for (int sz = 0; sz < 4; sz++)
        for (int ix = 0; ix < WORDS; ix++)
          for (int lo = 0; lo < 4; lo++) begin
            d = 32'h9E37_79B9 * n + 32'h1234_5678;
            n++;
            case (sz)
              0: begin off = (((be != 0) ? 3 : 0) ^ lo) * 8; model[ix][off +: 8] = d[7:0]; end
              1: begin off = ((((be != 0) ? 2 : 0) ^ lo) & 2) * 8; model[ix][off +: 16] = d[15:0]; end
              2: model[ix] = d;
              default: ;
            endcase
            step(1'b1, 5'(ix*4 + lo), 2'(sz), d, 1'(be), 1'b0);
            case (sz)
              0: check_line("R4");
              1: check_line("R3");
              2: check_line("R2");
              default: check_line("R9");
            endcase
            check_line("R5");
          end

    // R10: idle cycles leave the line alone
    step(1'b0, 5'd4, 2'd2, 32'hFFFF_FFFF, 1'b0, 1'b0);
    check_line("R10");

    // R8: clear alone
    step(1'b0, 5'd0, 2'd0, 32'h0, 1'b0, 1'b1);
    check("R8", {30'd0, dirty_hi, dirty_lo}, 32'd0);
    // R9: reserved size marks nothing
    step(1'b1, 5'd20, 2'd3, 32'hDEAD_BEEF, 1'b0, 1'b0);
    check("R9", {30'd0, dirty_hi, dirty_lo}, 32'd0);
    check_line("R9");
    // R6: low half boundary index 3
    step(1'b1, 5'd12, 2'd0, 32'h11, 1'b0, 1'b0);
    model[3][7:0] = 8'h11;
    check("R6", {30'd0, dirty_hi, dirty_lo}, 32'd1);
    // R6: high half boundary index 4
    step(1'b1, 5'd16, 2'd1, 32'h2222, 1'b1, 1'b0);
    model[4][31:16] = 16'h2222;
    check("R6", {30'd0, dirty_hi, dirty_lo}, 32'd3);
    // R7: further stores and idle keep both set
    step(1'b1, 5'd0, 2'd2, 32'h3333_3333, 1'b0, 1'b0);
    model[0] = 32'h3333_3333;
    check("R7", {30'd0, dirty_hi, dirty_lo}, 32'd3);
    step(1'b0, 5'd0, 2'd0, 32'h0, 1'b0, 1'b0);
    check("R7", {30'd0, dirty_hi, dirty_lo}, 32'd3);
    check_line("R7");
    // R8: clear with simultaneous store to high half
    step(1'b1, 5'd28, 2'd0, 32'h44, 1'b1, 1'b1);
    model[7][31:24] = 8'h44;
    check("R8", {30'd0, dirty_hi, dirty_lo}, 32'd2);
    check_line("R8");
    // R8: clear with simultaneous store to low half
    step(1'b1, 5'd5, 2'd0, 32'h55, 1'b0, 1'b1);
    model[1][15:8] = 8'h55;
    check("R8", {30'd0, dirty_hi, dirty_lo}, 32'd1);
    check_line("R8");

    // R1: reset again
    @(negedge clk); rst_n = 0;
    @(negedge clk);
    for (int k = 0; k < WORDS; k++) model[k] = '0;
    check_line("R1");
    check("R1", {30'd0, dirty_hi, dirty_lo}, 32'd0);

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule